// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block sends bytes as asynchronous serial characters: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts a fixed, parameterised number of clocks. A single-entry holding register takes each byte. The register signals that it is free through `tdr_empty_o`, and a byte written into it waits there until the shifter takes it.

A peer throttles the transmitter with an active-low clear-to-send input. The input first passes through a synchronizer. While the synchronized input is high, no new character begins and the line stays at its idle level of 1. A character that has already started always finishes. When characters follow each other, the transmitter decides whether the next one may start straight after the current stop bit by sampling the synchronized input at a fixed number of clocks before that stop bit ends. A change on the input after that point only affects later characters.

A sticky flag records every edge of the synchronized clear-to-send input. It stays set until a one-cycle clear pulse arrives.

Top module: `cts_uart_tx`

## Requirements
- R1: After reset, `tx_o` is 1, `tdr_empty_o` is 1 and `cts_flag_o` is 0.
- R2: Each character is one start bit of 0, then the 8 bits of the byte with bit 0 first, then one stop bit of 1. Every bit lasts CLKS_PER_BIT clocks.
- R3: A write is taken only while `tdr_empty_o` is 1, and `tdr_empty_o` goes to 0 the cycle after. A write while `tdr_empty_o` is 0 is ignored and the held byte is kept. `tdr_empty_o` returns to 1 on the cycle after the shifter takes the byte.
- R4: While the synchronized clear-to-send input is 1 and no character is in flight, a pending byte stays in the register and `tx_o` stays at 1.
- R5: A character that has started is sent in full, even if clear-to-send goes high while it is being sent.
- R6: The synchronized clear-to-send input is sampled on the clock that lies CTS_LEAD clocks before the end of the stop bit. If it is low then and a byte is pending, the next start bit follows the stop bit with no idle clock. This holds even if the input rises after the sample.
- R7: If the sample in R6 was not low, no back-to-back start occurs. The pending byte then starts from idle within a few clocks once the synchronized input is low.
- R8: The `cts_ni` input passes through a 2-flop synchronizer. Any rising or falling edge of the synchronized value sets `cts_flag_o` on the following cycle.
- R9: `cts_flag_o` stays at 1 until `cts_flag_clr_i` is pulsed. If a clear and a new edge happen in the same cycle, the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tdr_data_i | input | 8 | Byte to transmit |
| tdr_write_i | input | 1 | Write strobe for the holding register |
| tdr_empty_o | output | 1 | High when no byte is pending |
| cts_ni | input | 1 | Clear-to-send, active low, asynchronous |
| cts_flag_clr_i | input | 1 | One-cycle pulse that clears the change flag |
| cts_flag_o | output | 1 | Sticky flag for a clear-to-send change |
| tx_o | output | 1 | Serial line, idle level 1 |

## Verification
The bench builds the block with CLKS_PER_BIT = 8 and CTS_LEAD = 3. A frame then takes 80 clocks and the decision clock falls at offset 76 of each frame. This lets the bench place clear-to-send edges on a known clock on either side of the decision point, for example at offset 30 and at offset 78, and then measure the spacing between frame starts exactly. The short frame also leaves room within the run for long held periods, back-to-back streams and the case where a flag clear and a flag set meet in the same cycle.

// File: rtl/cts_tx_pkg.sv
package cts_tx_pkg;
  localparam int unsigned DEF_CLKS_PER_BIT = 16;
  localparam int unsigned DEF_DATA_W      = 8;
  localparam int unsigned DEF_CTS_LEAD    = 3;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_e;
endpackage

// File: rtl/cts_sync_flag.sv
module cts_sync_flag #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_ni,
  input  logic clr_i,
  output logic cts_s_o,
  output logic flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   edge_det;

  // reset to "not clear" so no edge is seen at reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cts_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cts_s_o  = sync_q[SYNC_STAGES-1];
  assign edge_det = cts_s_o ^ prev_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (edge_det) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_acc;

  assign wr_acc = wr_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take_i)      full_q <= 1'b0;
      else if (wr_acc) full_q <= 1'b1;
      if (wr_acc)      data_q <= data_i;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import cts_tx_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned CTS_LEAD     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cts_s_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int unsigned FRAME_BITS = DATA_W + 2;
  localparam int unsigned CNT_W      = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(CLKS_PER_BIT - 1 - CTS_LEAD);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);

  tx_state_e             state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  go_ok_q;
  logic                  busy;
  logic                  bit_end;
  logic                  frame_end;
  logic                  dl_point;
  logic                  load;

  assign busy      = (state_q == TX_SHIFT);
  assign bit_end   = busy && (cnt_q == CNT_LAST);
  assign frame_end = bit_end && (idx_q == IDX_LAST);
  assign dl_point  = busy && (idx_q == IDX_LAST) && (cnt_q == SAMPLE_AT);

  // from idle: live CTS; back-to-back: CTS latched at the deadline
  assign load = pend_i && ((!busy && !cts_s_i) || (frame_end && go_ok_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '1;
      go_ok_q <= 1'b0;
    end else begin
      if (load) begin
        state_q <= TX_SHIFT;
        cnt_q   <= '0;
        idx_q   <= '0;
        sh_q    <= {1'b1, data_i, 1'b0};
        go_ok_q <= 1'b0;
      end else begin
        if (frame_end) state_q <= TX_IDLE;
        if (dl_point)  go_ok_q <= !cts_s_i;
        if (busy) begin
          if (bit_end) begin
            cnt_q <= '0;
            idx_q <= idx_q + 1'b1;
            sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign load_o = load;
  assign busy_o = busy;
  assign tx_o   = busy ? sh_q[0] : 1'b1;
endmodule

// File: rtl/cts_uart_tx.sv
module cts_uart_tx
  import cts_tx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = DEF_CLKS_PER_BIT,
  parameter int unsigned CTS_LEAD     = DEF_CTS_LEAD,
  parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES,
  parameter int unsigned DATA_W       = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tdr_data_i,
  input  logic              tdr_write_i,
  output logic              tdr_empty_o,
  input  logic              cts_ni,
  input  logic              cts_flag_clr_i,
  output logic              cts_flag_o,
  output logic              tx_o
);
  logic              cts_s;
  logic              load;
  logic              busy;
  logic              full;
  logic [DATA_W-1:0] hold_data;

  cts_sync_flag #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cts_ni  (cts_ni),
    .clr_i   (cts_flag_clr_i),
    .cts_s_o (cts_s),
    .flag_o  (cts_flag_o)
  );

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (tdr_write_i),
    .data_i (tdr_data_i),
    .take_i (load),
    .data_o (hold_data),
    .full_o (full)
  );

  tx_frame_shifter #(
    .DATA_W       (DATA_W),
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .CTS_LEAD     (CTS_LEAD)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (full),
    .data_i  (hold_data),
    .cts_s_i (cts_s),
    .load_o  (load),
    .busy_o  (busy),
    .tx_o    (tx_o)
  );

  assign tdr_empty_o = !full;
endmodule

// File: rtl/cts_uart_tx_chk.sv
module cts_uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy,
  input logic cts_s,
  input logic load,
  input logic tx_o,
  input logic tdr_empty_o,
  input logic cts_flag_o,
  input logic cts_flag_clr_i
);
  AST_HELD_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && cts_s) |=> !busy); // R4
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> tx_o); // R4
  AST_LOAD_FREES_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> tdr_empty_o); // R3
  AST_PENDING_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tdr_empty_o && !load) |=> !tdr_empty_o); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_flag_o && !cts_flag_clr_i) |=> cts_flag_o); // R9
  AST_FLAG_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_s != $past(cts_s)) |=> cts_flag_o); // R8
endmodule

bind cts_uart_tx cts_uart_tx_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy           (busy),
  .cts_s          (cts_s),
  .load           (load),
  .tx_o           (tx_o),
  .tdr_empty_o    (tdr_empty_o),
  .cts_flag_o     (cts_flag_o),
  .cts_flag_clr_i (cts_flag_clr_i)
);

// File: tb/tb_cts_uart_tx.sv
`timescale 1ns/1ps
module tb_cts_uart_tx;
  localparam int CPB   = 8;
  localparam int LEAD  = 3;
  localparam int FRAME = 10 * CPB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       wr = 1'b0;
  logic       empty;
  logic       cts_n = 1'b1;
  logic       clr = 1'b0;
  logic       flag;
  logic       tx;

  int   n_vec = 0;
  int   n_err = 0;
  bit   done = 0;
  longint cyc = 0;
  logic [7:0] exp_q[$];
  longint     starts[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cts_uart_tx #(.CLKS_PER_BIT(CPB), .CTS_LEAD(LEAD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tdr_data_i(data), .tdr_write_i(wr),
    .tdr_empty_o(empty), .cts_ni(cts_n), .cts_flag_clr_i(clr),
    .cts_flag_o(flag), .tx_o(tx)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit expect_taken);
    @(negedge clk); data = b; wr = 1'b1;
    if (expect_taken) exp_q.push_back(b);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_start();
    logic p;
    p = tx;
    forever begin
      @(negedge clk);
      if (p && !tx) break;
      p = tx;
    end
  endtask

  task automatic wait_empty();
    while (!empty) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // monitor: rebuild frames from the line and compare against the scoreboard
  initial begin
    logic prev;
    logic [9:0] bits;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx) begin
        starts.push_back(cyc);
        repeat (CPB/2) @(negedge clk);
        bits[0] = tx;
        for (int i = 1; i < 10; i++) begin
          repeat (CPB) @(negedge clk);
          bits[i] = tx;
        end
        check(bits[0] == 1'b0 && bits[9] == 1'b1, "R2 framing", {bits[9], bits[0]}, 2'b10);
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected frame", bits[8:1], -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(bits[8:1] == e, "R2/R5 data", bits[8:1], e);
        end
        prev = 1'b1;
      end else begin
        prev = tx;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int bad;
    longint s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx == 1'b1, "R1 tx", tx, 1);
    check(empty == 1'b1, "R1 empty", empty, 1);
    check(flag == 1'b0, "R1 flag", flag, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx == 1'b1 && empty && !flag, "R1 after release", {tx, empty, flag}, 3'b110);

    // simple frame, CTS low
    cts_n = 1'b0;
    repeat (6) @(negedge clk);
    pulse_clr();
    @(negedge clk); data = 8'hA5; wr = 1'b1; exp_q.push_back(8'hA5);
    @(negedge clk); wr = 1'b0;
    check(!empty, "R3 empty low after write", empty, 0);
    wait_start();
    repeat (FRAME + 4) @(negedge clk);

    // back-to-back stream: R6
    send(8'h3C, 1);
    wait_start();
    s0 = starts[starts.size()-1];
    send(8'hC3, 1);
    check(!empty, "R3 byte pending while in flight", empty, 0);
    repeat (FRAME) @(negedge clk);
    check(starts.size() >= 2 && starts[starts.size()-1] - s0 == FRAME, "R6 no idle gap",
          starts[starts.size()-1] - s0, FRAME);
    repeat (FRAME + 4) @(negedge clk);
    check(empty, "R3 empty after load", empty, 1);

    // early CTS high: current completes (R5), next held (R4)
    pulse_clr();
    send(8'h0F, 1);
    wait_start();
    send(8'hF0, 1);
    repeat (28) @(negedge clk);
    cts_n = 1'b1;
    repeat (6) @(negedge clk);
    check(flag, "R8 flag on rising CTS", flag, 1);
    repeat (FRAME) @(negedge clk);
    send(8'h77, 0); // register full: must be dropped (R3)
    bad = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (!tx || empty) bad++;
    end
    check(bad == 0, "R4 line idle while held", bad, 0);
    pulse_clr();
    check(!flag, "R9 clear pulse", flag, 0);
    cts_n = 1'b0;
    repeat (6) @(negedge clk);
    check(flag, "R8 flag on falling CTS", flag, 1);
    repeat (2 * FRAME) @(negedge clk);
    check(exp_q.size() == 0 && empty, "R3/R4 held byte sent once", exp_q.size(), 0);

    // late CTS high after the deadline: next still starts back-to-back (R6)
    send(8'h55, 1);
    wait_start();
    s0 = starts[starts.size()-1];
    send(8'hAA, 1);
    repeat (76) @(negedge clk); // offset 78
    cts_n = 1'b1;
    repeat (8) @(negedge clk);
    check(starts[starts.size()-1] - s0 == FRAME, "R6 late rise ignored",
          starts[starts.size()-1] - s0, FRAME);
    repeat (FRAME) @(negedge clk);

    // CTS high at the deadline, low just after: starts from idle (R7)
    cts_n = 1'b0;
    repeat (6) @(negedge clk);
    send(8'h11, 1);
    wait_start();
    s0 = starts[starts.size()-1];
    send(8'h22, 1);
    repeat (28) @(negedge clk); // offset 30
    cts_n = 1'b1;
    repeat (48) @(negedge clk); // offset 78
    cts_n = 1'b0;
    repeat (12) @(negedge clk);
    check(starts.size() > 0 && starts[starts.size()-1] - s0 > FRAME &&
          starts[starts.size()-1] - s0 <= FRAME + 4, "R7 start after deadline miss",
          starts[starts.size()-1] - s0, FRAME + 1);
    repeat (FRAME + 4) @(negedge clk);

    // clear and edge in the same cycle: set wins (R9)
    pulse_clr();
    check(!flag, "R9 cleared", flag, 0);
    @(negedge clk); cts_n = 1'b1;
    @(negedge clk);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(flag, "R9 set wins over clear", flag, 1);
    repeat (3) @(negedge clk);
    check(flag, "R9 sticky", flag, 1);

    check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule